// File: doc/BRIEF.md
# Fraction-Saving DC Removal Filter

This block strips the constant (zero-frequency) part from a stream of samples that can arrive on every clock. It is a first-order recursive high-pass stage. Each accepted sample is first turned into a signed value. The filter then takes the difference from the previous accepted sample and adds a leaky copy of the previous output, scaled by the pole 1 - 2^-POLE_SHIFT. That product needs no multiplier: it is the previous output minus itself shifted right. The result is rounded down to the output width, and it saturates at the signed range limits.

The fractional part lost in the rounding is kept in a small register and put back into the next sample's sum, so that truncation does not leave a standing offset at the output. The whole recursion, from the stored output and the stored remainder to the next output, settles within one clock. The block can therefore take back-to-back samples with no stall. It is placed directly in a sample path: drive `valid_i` with each new word, and the filtered word appears with `valid_o` one clock later.

Top module: `dc_blocker`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `data_o` is 0. The stored previous input, previous output and remainder are all zero, so the first sample after reset produces its own signed value as output.
- R2: With the default offset-binary input format, code 0x8000 means zero. The signed value is the code with its most significant bit inverted, so 0x0000 is -32768 and 0xFFFF is +32767.
- R3: `valid_o` is high in exactly the cycle after a cycle in which `valid_i` was high at the clock edge. `data_o` carries the result of that sample as a signed two's-complement word.
- R4: For each accepted sample, the exact sum with POLE_SHIFT fractional bits is s = (x - x_prev) + (y_prev - y_prev*2^-POLE_SHIFT) + r_prev. The output y is floor(s), limited to the output range.
- R5: The stored remainder r is the fractional part s - floor(s), held as POLE_SHIFT bits. It is taken from s even when the output saturates.
- R6: If floor(s) is above +32767 or below -32768, the output is +32767 or -32768 respectively, and it never wraps.
- R7: On a cycle with `valid_i` low, none of the stored state changes and `data_o` holds its value, whatever `data_i` carries.
- R8: A constant input held long enough drives the output to exactly 0, and it stays there.
- R9: Samples on consecutive clocks are each accepted, and every one produces its own bit-exact output on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one sample may be taken per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks `data_i` as a new sample this cycle |
| data_i | input | DATA_W | Input sample (offset binary by default) |
| valid_o | output | 1 | Marks `data_o` as a new filtered sample |
| data_o | output | DATA_W | Filtered sample, signed two's complement |

## Verification
The bench builds the block with its defaults: a 16-bit word, POLE_SHIFT of 6 and offset-binary input. With a pole shift of 6 the time constant is 64 samples, so a full-scale step decays to exactly zero within a short run, and the remainder's final walk toward zero can be watched to the last count. The 16-bit width lets rail-to-rail input steps of 65535 codes push the sum past both output limits, which exercises saturation and the remainder-under-saturation rule. Every output is compared bit-exactly against an integer model for low-noise, full-range and gapped streams.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  typedef enum logic [0:0] {
    IN_OFFSET_BIN = 1'b0,
    IN_TWOS_COMP  = 1'b1
  } in_fmt_e;
endpackage

// File: rtl/dcb_diff.sv
// Input format conversion, previous-sample register and first difference.
module dcb_diff #(
  parameter int              DATA_W = 16,
  parameter dcb_pkg::in_fmt_e IN_FMT = dcb_pkg::IN_OFFSET_BIN
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic signed [DATA_W:0]   diff_o
);
  logic signed [DATA_W-1:0] x_s;
  logic signed [DATA_W-1:0] x_prev_q;

  generate
    if (IN_FMT == dcb_pkg::IN_OFFSET_BIN) begin : g_offset
      assign x_s = {~data_i[DATA_W-1], data_i[DATA_W-2:0]};
    end else begin : g_twos
      assign x_s = data_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      x_prev_q <= '0;
    else if (valid_i) x_prev_q <= x_s;
  end

  assign diff_o = {x_s[DATA_W-1], x_s} - {x_prev_q[DATA_W-1], x_prev_q};
endmodule

// File: rtl/dcb_pole.sv
// Feedback product y*(1 - 2^-SHIFT), scaled by 2^SHIFT so it stays exact.
module dcb_pole #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 6,
  parameter int ACC_W  = DATA_W + SHIFT + 3
) (
  input  logic signed [DATA_W-1:0] y_i,
  output logic signed [ACC_W-1:0]  prod_o
);
  logic signed [ACC_W-1:0] y_ext;
  assign y_ext  = {{(ACC_W-DATA_W){y_i[DATA_W-1]}}, y_i};
  assign prod_o = (y_ext <<< SHIFT) - y_ext;
endmodule

// File: rtl/dcb_quant.sv
// Floor to integer, saturate to output range, split off the remainder.
module dcb_quant #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 6,
  parameter int ACC_W  = DATA_W + SHIFT + 3
) (
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic signed [DATA_W-1:0] y_o,
  output logic [SHIFT-1:0]         rem_o
);
  localparam int INT_W = ACC_W - SHIFT;
  localparam logic signed [INT_W-1:0] MAX_V = INT_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [INT_W-1:0] MIN_V = -MAX_V - INT_W'(1);

  logic signed [INT_W-1:0] int_part;
  assign int_part = acc_i[ACC_W-1:SHIFT];
  assign rem_o    = acc_i[SHIFT-1:0];

  always_comb begin
    if (int_part > MAX_V)      y_o = MAX_V[DATA_W-1:0];
    else if (int_part < MIN_V) y_o = MIN_V[DATA_W-1:0];
    else                       y_o = int_part[DATA_W-1:0];
  end
endmodule

// File: rtl/dc_blocker.sv
module dc_blocker #(
  parameter int               DATA_W     = 16,
  parameter int               POLE_SHIFT = 6,
  parameter dcb_pkg::in_fmt_e IN_FMT     = dcb_pkg::IN_OFFSET_BIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int ACC_W = DATA_W + POLE_SHIFT + 3;

  logic signed [DATA_W:0]   diff;
  logic signed [ACC_W-1:0]  diff_sc;
  logic signed [ACC_W-1:0]  prod;
  logic signed [ACC_W-1:0]  acc;
  logic signed [DATA_W-1:0] y_q;
  logic signed [DATA_W-1:0] y_n;
  logic [POLE_SHIFT-1:0]    rem_q;
  logic [POLE_SHIFT-1:0]    rem_n;
  logic                     valid_q;

  dcb_diff #(.DATA_W(DATA_W), .IN_FMT(IN_FMT)) u_diff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .diff_o  (diff)
  );

  dcb_pole #(.DATA_W(DATA_W), .SHIFT(POLE_SHIFT), .ACC_W(ACC_W)) u_pole (
    .y_i    (y_q),
    .prod_o (prod)
  );

  // Whole loop closes combinationally: y_q/rem_q -> acc -> y_n/rem_n.
  assign diff_sc = {{(ACC_W-DATA_W-1){diff[DATA_W]}}, diff} <<< POLE_SHIFT;
  assign acc     = diff_sc + prod + {{(ACC_W-POLE_SHIFT){1'b0}}, rem_q};

  dcb_quant #(.DATA_W(DATA_W), .SHIFT(POLE_SHIFT), .ACC_W(ACC_W)) u_quant (
    .acc_i (acc),
    .y_o   (y_n),
    .rem_o (rem_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= '0;
      rem_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        y_q   <= y_n;
        rem_q <= rem_n;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = y_q;
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 6,
  parameter int ACC_W  = DATA_W + SHIFT + 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_i,
  input logic                     valid_o,
  input logic [DATA_W-1:0]        data_o,
  input logic signed [ACC_W-1:0]  acc_i,
  input logic signed [DATA_W-1:0] y_n_i,
  input logic [SHIFT-1:0]         rem_n_i
);
  localparam int INT_W = ACC_W - SHIFT;
  localparam logic signed [INT_W-1:0] MAX_V = INT_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [INT_W-1:0] MIN_V = -MAX_V - INT_W'(1);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  logic signed [INT_W-1:0] whole;
  logic signed [ACC_W-1:0] rebuilt;
  logic in_range;
  assign whole    = acc_i[ACC_W-1:SHIFT];
  assign in_range = (whole <= MAX_V) && (whole >= MIN_V);
  assign rebuilt  = ({{(ACC_W-DATA_W){y_n_i[DATA_W-1]}}, y_n_i} <<< SHIFT)
                  + {{(ACC_W-SHIFT){1'b0}}, rem_n_i};

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && data_o == '0));

  a_r3_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (valid_o == $past(valid_i)));

  a_r7_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(valid_i)) |-> $stable(data_o));

  a_r5_exact_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_range |-> (rebuilt == acc_i));

  a_r6_sat_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (whole > MAX_V) |-> (y_n_i == MAX_V[DATA_W-1:0]));

  a_r6_sat_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (whole < MIN_V) |-> (y_n_i == MIN_V[DATA_W-1:0]));
endmodule

bind dc_blocker dcb_checker #(
  .DATA_W (DATA_W),
  .SHIFT  (POLE_SHIFT),
  .ACC_W  (DATA_W + POLE_SHIFT + 3)
) u_dcb_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .data_o  (data_o),
  .acc_i   (acc),
  .y_n_i   (y_n),
  .rem_n_i (rem_n)
);

// File: tb/dc_blocker_bench.sv
module dc_blocker_bench;
  localparam int SH = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        valid_o;
  logic [15:0] data_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;

  int m_x, m_y, m_r;
  logic [31:0] lfsr = 32'h1ACE_5EED;

  always #5 clk_i = ~clk_i;

  dc_blocker u_dc_blocker (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_step(input logic [15:0] code);
    int xs, w, yi;
    xs = int'({1'b0, code}) - 32768;
    w  = ((xs - m_x) <<< SH) + ((m_y <<< SH) - m_y) + m_r;
    yi = w >>> SH;
    m_r = w & ((1 << SH) - 1);
    if (yi > 32767) yi = 32767;
    if (yi < -32768) yi = -32768;
    m_x = xs;
    m_y = yi;
    return yi;
  endfunction

  function automatic logic [15:0] next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[15:0];
  endfunction

  // Called at a falling edge; returns at the next falling edge.
  task automatic send(input logic [15:0] code, input string req);
    int exp, act;
    data_i  = code;
    valid_i = 1'b1;
    exp = model_step(code);
    @(posedge clk_i);
    @(negedge clk_i);
    check({req, " valid_o"}, int'(valid_o), 1);
    act = int'($signed(data_o));
    check(req, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    valid_i = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk_i);
    check("R1 reset valid_o", int'(valid_o), 0);
    check("R1 reset data_o", int'($signed(data_o)), 0);
    rst_ni = 1'b1;
    m_x = 0; m_y = 0; m_r = 0;
  endtask

  task automatic t_first_sample();
    do_reset();
    send(16'h8000 + 16'd1000, "R1 first sample equals centred input");
    check("R2 offset 0x8000+1000 -> 1000", int'($signed(data_o)), 1000);
    send(16'h8000, "R4 return to centre code");
    valid_i = 1'b0;
    @(negedge clk_i);
    check("R3 valid_o drops after idle", int'(valid_o), 0);
  endtask

  task automatic t_saturation();
    do_reset();
    send(16'h0000, "R2 code 0x0000 is -32768");
    check("R2 min code", int'($signed(data_o)), -32768);
    send(16'hFFFF, "R6 positive saturation");
    check("R6 clamps high", int'($signed(data_o)), 32767);
    send(16'h0000, "R6 negative saturation");
    check("R6 clamps low", int'($signed(data_o)), -32768);
    send(16'hFFFF, "R5 remainder kept across saturation");
    send(16'hFFFF, "R5 decay after saturation");
    valid_i = 1'b0;
  endtask

  task automatic t_gap();
    int held;
    do_reset();
    send(16'h9234, "R4 before gap");
    send(16'h7001, "R4 before gap 2");
    held = int'($signed(data_o));
    valid_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      data_i = next_rand();
      @(negedge clk_i);
      check("R7 valid_o low in gap", int'(valid_o), 0);
      check("R7 data_o held in gap", int'($signed(data_o)), held);
    end
    send(16'h8100, "R7 state untouched by gap");
    send(16'h8100, "R7 state untouched by gap 2");
    valid_i = 1'b0;
  endtask

  task automatic t_constant_decay();
    do_reset();
    for (int i = 0; i < 1500; i++) send(16'hC000, "R8 constant input tracking");
    check("R8 constant input settles to zero", int'($signed(data_o)), 0);
    for (int i = 0; i < 50; i++) send(16'hC000, "R8 stays at zero");
    check("R8 still zero", int'($signed(data_o)), 0);
    for (int i = 0; i < 1500; i++) send(16'h1000, "R8 negative constant");
    check("R8 negative side settles to zero", int'($signed(data_o)), 0);
    valid_i = 1'b0;
  endtask

  task automatic t_streams();
    do_reset();
    for (int i = 0; i < 800; i++)
      send(16'h9000 + {4'h0, next_rand() & 16'h0FFF}, "R9 back-to-back low noise on offset");
    for (int i = 0; i < 400; i++)
      send(next_rand(), "R4 full-range stream");
    for (int i = 0; i < 200; i++) begin
      if (next_rand() & 16'h1) send(next_rand(), "R9 sparse stream");
      else begin
        valid_i = 1'b0;
        data_i  = next_rand();
        @(negedge clk_i);
        check("R3 no valid_o without valid_i", int'(valid_o), 0);
      end
    end
    valid_i = 1'b0;
  endtask

  initial begin
    m_x = 0; m_y = 0; m_r = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1 reset valid_o", int'(valid_o), 0);
    check("R1 reset data_o", int'($signed(data_o)), 0);
    rst_ni = 1'b1;
    t_first_sample();
    t_saturation();
    t_gap();
    t_constant_decay();
    t_streams();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule